// File: doc/BRIEF.md
# Row-Aware Flash Write Segmenter

This block sits between a software-facing request port and an embedded flash controller. A program request carries a byte offset, a byte length and a bank hint, and a byte stream delivers its data. The block cuts the request into batches that fit the controller's word buffer and never cross a flash row. It packs each batch into 32-bit words, loads the controller's write buffer, and issues one program command per attempt. It polls the controller until the command finishes, reads the error register, and retries within a bounded number of attempts. Erase requests go through the same command, poll and retry path, one page per command.

Each finished request ends with a one-cycle `done` pulse and a status code. When a request fails, the block also reports the byte offset of the batch that failed. The flash controller itself is outside the block.

Top module: `flash_row_segmenter`

## Requirements
- R1: A request is rejected with status 1 in the cycle after it is accepted, with no command issued and no source byte consumed, in any of these cases: a program request whose offset or length is not a multiple of 4; an erase request whose offset or length is not a multiple of PAGE_BYTES; or an erase request aimed at the info bank.
- R2: A program request is split into batches in ascending order. Each batch is the smallest of three sizes: the remaining bytes, BATCH_WORDS*4 bytes, and the distance to the next ROW_BYTES boundary. `cmd_size` carries the batch word count minus one.
- R3: Source bytes are packed little-endian: the first byte of each group of four lands in bits 7:0. Word k of a batch is written at buffer index k before that batch's first command.
- R4: On the main array, an offset at or above HALF_BYTES selects bank 1 (`cmd_bank`=1) and HALF_BYTES is subtracted from it. An offset below HALF_BYTES selects bank 0 with the offset unchanged. An info-bank request sets `cmd_info`=1 and bank 1 and keeps its offset. `cmd_word_off` is the local byte offset divided by 4.
- R5: An attempt that finishes with a nonzero `ctl_err` is retried. Each batch allows at most PROG_TRIES program attempts (one more once the extra pulse of R6 has been granted) or ERASE_TRIES erase attempts. Once these are used up, the request ends with status 4.
- R6: After the first program attempt of a batch that finishes with zero error, exactly one more program command is issued for that batch. The batch is done only when an attempt finishes clean after that point. Erase batches get no extra pulse.
- R7: Before each command, `ctl_err` must read zero within CLR_POLLS consecutive cycles. Otherwise the request ends with status 2 and no command is issued.
- R8: If `ctl_busy` stays high for DONE_POLLS cycles after a command, the request ends with status 3.
- R9: A failed batch stops the request; no later batch is started. `fail_offset` gives the global byte offset of the failing batch, or the request offset for a rejection.
- R10: An erase issues one command per page in ascending address order, with `cmd_erase`=1 and `cmd_size`=0.
- R11: After reset, `busy`, `done`, `cmd_valid` and `src_ready` are low. `done` is a single-cycle pulse. A zero-length program request ends with status 0 in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_info | input | 1 | Target the info bank |
| req_offset | input | OFFW | Global byte offset |
| req_len | input | OFFW+1 | Byte length |
| busy | output | 1 | A request is in progress |
| src_valid | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte accepted when valid |
| wbuf_we | output | 1 | Write buffer write enable |
| wbuf_idx | output | log2(BATCH_WORDS) | Write buffer word index |
| wbuf_data | output | 32 | Write buffer word |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_erase | output | 1 | Command is an erase |
| cmd_info | output | 1 | Command targets the info bank |
| cmd_bank | output | 1 | Bank select |
| cmd_word_off | output | OFFW-2 | Word offset inside the bank |
| cmd_size | output | log2(BATCH_WORDS) | Word count minus one |
| ctl_busy | input | 1 | Controller operation in progress |
| ctl_err | input | ERRW | Controller error status, nonzero on error |
| done | output | 1 | Request finished pulse |
| status | output | 3 | 0 ok, 1 rejected, 2 error stuck, 3 timeout, 4 retries used up |
| fail_offset | output | OFFW | Byte offset of the failing batch |

## Verification
The bench builds the block with HALF_BYTES=8192, keeps ROW_BYTES=256, BATCH_WORDS=32 and PAGE_BYTES=2048, and lowers the limits to PROG_TRIES=3, ERASE_TRIES=4, CLR_POLLS=6 and DONE_POLLS=20. With the small half size, random requests often land in the second bank, and an erase can cross into bank 1. With the short limits, retry exhaustion, a stuck error and a completion timeout each happen within a few dozen cycles, so they can be checked directly next to the clean program and erase cases.

// File: rtl/fws_pkg.sv
// Shared types for the row-aware flash write segmenter.
// Assumes: status codes are visible to software as plain 3-bit values.
package fws_pkg;
    typedef enum logic [2:0] {
        FWS_OK        = 3'd0,
        FWS_REJECT    = 3'd1,
        FWS_ERR_STUCK = 3'd2,
        FWS_TIMEOUT   = 3'd3,
        FWS_RETRY_OUT = 3'd4
    } fws_code_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_CLEAR, S_ISSUE, S_WAIT, S_DONE
    } fws_state_e;
endpackage

// File: rtl/fws_batch_plan.sv
// Batch planner: from the current offset and the remaining length it derives
// the size of the next batch and the bank-local word offset of that batch.
// Assumes: ROW_BYTES and HALF_BYTES are powers of two, and HALF_BYTES is a
// multiple of ROW_BYTES, so no batch spans two banks.
module fws_batch_plan #(
    parameter int unsigned HALF_BYTES  = 262144,
    parameter int unsigned ROW_BYTES   = 256,
    parameter int unsigned BATCH_WORDS = 32,
    parameter int unsigned PAGE_BYTES  = 2048,
    parameter int unsigned OFFW        = 19,
    parameter int unsigned LENW        = 20
) (
    input  logic [OFFW-1:0] off,
    input  logic [LENW-1:0] rem,
    input  logic            erase,
    input  logic            info,
    output logic [LENW-1:0] nbytes,
    output logic            bank,
    output logic [OFFW-3:0] word_off
);
    localparam int unsigned ROWB = $clog2(ROW_BYTES);
    localparam int unsigned CAP  = BATCH_WORDS * 4;

    logic [LENW-1:0] to_row;
    logic [OFFW-1:0] local_off;

    // Size: smallest of remaining, buffer capacity and distance to row end.
    always_comb begin
        to_row = LENW'(ROW_BYTES) - LENW'(off[ROWB-1:0]);
        nbytes = rem;
        if (nbytes > LENW'(CAP)) nbytes = LENW'(CAP);
        if (nbytes > to_row)     nbytes = to_row;
        if (erase)               nbytes = LENW'(PAGE_BYTES);
    end

    // Bank split: the upper half of the main array maps to bank 1.
    always_comb begin
        if (info) begin
            bank      = 1'b1;
            local_off = off;
        end else if (off >= OFFW'(HALF_BYTES)) begin
            bank      = 1'b1;
            local_off = off - OFFW'(HALF_BYTES);
        end else begin
            bank      = 1'b0;
            local_off = off;
        end
        word_off = local_off[OFFW-1:2];
    end
endmodule

// File: rtl/fws_word_packer.sv
// Byte-to-word packer: accepts source bytes until the target word count is
// reached and emits each completed word little-endian into the write buffer.
// Assumes: clear is held whenever the owner is not loading a batch.
module fws_word_packer #(
    parameter int unsigned BATCH_WORDS = 32,
    parameter int unsigned IDXW        = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [IDXW:0]   target,
    input  logic            src_valid,
    input  logic [7:0]      src_data,
    output logic            src_ready,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [31:0]     wr_data,
    output logic [IDXW:0]   words
);
    logic [1:0]  bcnt;
    logic [23:0] acc;

    assign src_ready = !clear && (words != target);

    // Collect bytes and push out a full word after every fourth byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bcnt    <= '0;
            acc     <= '0;
            words   <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (src_valid && src_ready) begin
                if (bcnt == 2'd3) begin
                    wr_en   <= 1'b1;
                    wr_data <= {src_data, acc};
                    wr_idx  <= words[IDXW-1:0];
                    words   <= words + 1'b1;
                    bcnt    <= '0;
                end else begin
                    acc[8*bcnt +: 8] <= src_data;
                    bcnt             <= bcnt + 1'b1;
                end
            end
        end
    end

    // R3
    wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/fws_poll_timer.sv
// Poll window counter: counts cycles while run is high and flags the last
// cycle of a LIMIT-cycle window. Clears whenever run drops.
// Assumes: LIMIT >= 1.
module fws_poll_timer #(
    parameter int unsigned LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count polls inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_row_segmenter.sv
// Row-aware flash write segmenter. Splits program requests into
// row-bounded batches, loads the controller write buffer, issues commands
// with retry and an extra program pulse, and handles erases page by page.
// Assumes: the controller accepts a command on cmd_valid and raises
// ctl_busy by the next cycle; ctl_err is valid whenever ctl_busy is low.
module flash_row_segmenter #(
    parameter int unsigned HALF_BYTES  = 262144,
    parameter int unsigned ROW_BYTES   = 256,
    parameter int unsigned BATCH_WORDS = 32,
    parameter int unsigned PAGE_BYTES  = 2048,
    parameter int unsigned PROG_TRIES  = 9,
    parameter int unsigned ERASE_TRIES = 45,
    parameter int unsigned CLR_POLLS   = 50,
    parameter int unsigned DONE_POLLS  = 1500,
    parameter int unsigned ERRW        = 8,
    localparam int unsigned OFFW       = $clog2(2 * HALF_BYTES),
    localparam int unsigned LENW       = OFFW + 1,
    localparam int unsigned IDXW       = $clog2(BATCH_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_erase,
    input  logic            req_info,
    input  logic [OFFW-1:0] req_offset,
    input  logic [LENW-1:0] req_len,
    output logic            busy,
    input  logic            src_valid,
    input  logic [7:0]      src_data,
    output logic            src_ready,
    output logic            wbuf_we,
    output logic [IDXW-1:0] wbuf_idx,
    output logic [31:0]     wbuf_data,
    output logic            cmd_valid,
    output logic            cmd_erase,
    output logic            cmd_info,
    output logic            cmd_bank,
    output logic [OFFW-3:0] cmd_word_off,
    output logic [IDXW-1:0] cmd_size,
    input  logic            ctl_busy,
    input  logic [ERRW-1:0] ctl_err,
    output logic            done,
    output logic [2:0]      status,
    output logic [OFFW-1:0] fail_offset
);
    import fws_pkg::*;

    localparam int unsigned ATW       = $clog2(ERASE_TRIES + PROG_TRIES + 2);
    localparam int unsigned ROW_WORDS = ROW_BYTES / 4;
    localparam int unsigned PAGE_WORDS = PAGE_BYTES / 4;

    fws_state_e      state;
    logic [OFFW-1:0] cur_off;
    logic [LENW-1:0] rem;
    logic            is_erase, is_info, extra_done;
    logic [ATW-1:0]  attempts;
    logic [LENW-1:0] bat_bytes;
    logic [IDXW:0]   bat_words;
    logic [IDXW:0]   pk_words;
    logic            clr_expired, wait_expired;
    logic            bad_req;
    logic [ATW-1:0]  limit;

    fws_batch_plan #(
        .HALF_BYTES(HALF_BYTES), .ROW_BYTES(ROW_BYTES),
        .BATCH_WORDS(BATCH_WORDS), .PAGE_BYTES(PAGE_BYTES),
        .OFFW(OFFW), .LENW(LENW)
    ) plan_i (
        .off(cur_off), .rem(rem), .erase(is_erase), .info(is_info),
        .nbytes(bat_bytes), .bank(cmd_bank), .word_off(cmd_word_off)
    );

    assign bat_words = bat_bytes[IDXW+2:2];

    fws_word_packer #(.BATCH_WORDS(BATCH_WORDS), .IDXW(IDXW)) pack_i (
        .clk(clk), .rst_n(rst_n), .clear(state != S_LOAD),
        .target(bat_words), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .wr_en(wbuf_we), .wr_idx(wbuf_idx),
        .wr_data(wbuf_data), .words(pk_words)
    );

    fws_poll_timer #(.LIMIT(CLR_POLLS)) clr_tmr_i (
        .clk(clk), .rst_n(rst_n), .run(state == S_CLEAR), .expired(clr_expired)
    );

    fws_poll_timer #(.LIMIT(DONE_POLLS)) wait_tmr_i (
        .clk(clk), .rst_n(rst_n), .run(state == S_WAIT), .expired(wait_expired)
    );

    // Request legality check on the incoming fields.
    always_comb begin
        if (req_erase)
            bad_req = req_info
                   || ((req_offset & OFFW'(PAGE_BYTES - 1)) != '0)
                   || ((req_len & LENW'(PAGE_BYTES - 1)) != '0);
        else
            bad_req = (req_offset[1:0] != 2'b00) || (req_len[1:0] != 2'b00);
    end

    // Attempt ceiling for the current batch.
    always_comb begin
        if (is_erase) limit = ATW'(ERASE_TRIES);
        else          limit = ATW'(PROG_TRIES) + ATW'(extra_done);
    end

    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);
    assign cmd_valid = (state == S_ISSUE);
    assign cmd_erase = is_erase;
    assign cmd_info  = is_info;
    assign cmd_size  = is_erase ? '0 : IDXW'(bat_words - 1'b1);

    // Main sequencer: load, clear check, issue, wait, judge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            cur_off     <= '0;
            rem         <= '0;
            is_erase    <= 1'b0;
            is_info     <= 1'b0;
            extra_done  <= 1'b0;
            attempts    <= '0;
            status      <= FWS_OK;
            fail_offset <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    cur_off     <= req_offset;
                    rem         <= req_len;
                    is_erase    <= req_erase;
                    is_info     <= req_info;
                    attempts    <= '0;
                    extra_done  <= 1'b0;
                    status      <= FWS_OK;
                    fail_offset <= '0;
                    if (bad_req) begin
                        status      <= FWS_REJECT;
                        fail_offset <= req_offset;
                        state       <= S_DONE;
                    end else if (req_len == '0) state <= S_DONE;
                    else if (req_erase)         state <= S_CLEAR;
                    else                        state <= S_LOAD;
                end
                S_LOAD: if (pk_words == bat_words) state <= S_CLEAR;
                S_CLEAR: begin
                    if (ctl_err == '0) state <= S_ISSUE;
                    else if (clr_expired) begin
                        status      <= FWS_ERR_STUCK;
                        fail_offset <= cur_off;
                        state       <= S_DONE;
                    end
                end
                S_ISSUE: begin
                    attempts <= attempts + 1'b1;
                    state    <= S_WAIT;
                end
                S_WAIT: begin
                    if (!ctl_busy) begin
                        if (ctl_err != '0) begin
                            if (attempts == limit) begin
                                status      <= FWS_RETRY_OUT;
                                fail_offset <= cur_off;
                                state       <= S_DONE;
                            end else state <= S_CLEAR;
                        end else if (!is_erase && !extra_done) begin
                            extra_done <= 1'b1;
                            state      <= S_CLEAR;
                        end else begin
                            cur_off    <= cur_off + OFFW'(bat_bytes);
                            rem        <= rem - bat_bytes;
                            attempts   <= '0;
                            extra_done <= 1'b0;
                            if (rem == bat_bytes) state <= S_DONE;
                            else if (is_erase)    state <= S_CLEAR;
                            else                  state <= S_LOAD;
                        end
                    end else if (wait_expired) begin
                        status      <= FWS_TIMEOUT;
                        fail_offset <= cur_off;
                        state       <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    row_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_erase) |->
        ((int'(cmd_word_off) % ROW_WORDS) + int'(cmd_size) < ROW_WORDS));

    // R10
    page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_erase) |->
        ((int'(cmd_word_off) % PAGE_WORDS) == 0 && cmd_size == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    issue_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(ctl_err) == '0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_ready && !cmd_valid && !wbuf_we));
endmodule

// File: tb/flash_row_segmenter_tb_top.sv
module flash_row_segmenter_tb_top;
    localparam int PERIOD = 10;
    localparam int HALF = 8192;
    localparam int ROW = 256;
    localparam int BW = 32;
    localparam int PAGE = 2048;
    localparam int PT = 3;
    localparam int ET = 4;
    localparam int OFFW = 14;
    localparam int LENW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_erase = 1'b0, req_info = 1'b0;
    logic [OFFW-1:0] req_offset = '0;
    logic [LENW-1:0] req_len = '0;
    logic busy, src_ready, wbuf_we, cmd_valid, cmd_erase, cmd_info, cmd_bank, done;
    logic [7:0] src_data;
    logic [4:0] wbuf_idx, cmd_size;
    logic [31:0] wbuf_data;
    logic [OFFW-3:0] cmd_word_off;
    logic ctl_busy;
    logic [7:0] ctl_err;
    logic [2:0] status;
    logic [OFFW-1:0] fail_offset;

    always #(PERIOD/2) clk = ~clk;

    flash_row_segmenter #(
        .HALF_BYTES(HALF), .ROW_BYTES(ROW), .BATCH_WORDS(BW), .PAGE_BYTES(PAGE),
        .PROG_TRIES(PT), .ERASE_TRIES(ET), .CLR_POLLS(6), .DONE_POLLS(20), .ERRW(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_info(req_info), .req_offset(req_offset), .req_len(req_len),
        .busy(busy), .src_valid(1'b1), .src_data(src_data), .src_ready(src_ready),
        .wbuf_we(wbuf_we), .wbuf_idx(wbuf_idx), .wbuf_data(wbuf_data),
        .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_info(cmd_info),
        .cmd_bank(cmd_bank), .cmd_word_off(cmd_word_off), .cmd_size(cmd_size),
        .ctl_busy(ctl_busy), .ctl_err(ctl_err), .done(done), .status(status),
        .fail_offset(fail_offset)
    );

    // Stub controls
    int err_lo = 0, err_hi = 0;
    bit stuck = 0, hang = 0;
    int cur_req_off = 0;

    // Stub state and log
    int feed, n_cmd, att, bcnt, ehold;
    bit this_err;
    logic [31:0] wbuf [BW];
    int lg_woff [64];
    int lg_size [64];
    int lg_bank [64];
    int lg_info [64];
    int lg_erase [64];
    bit lg_dok [64];

    function automatic logic [7:0] pat(int i);
        return 8'((i * 13 + 8'h5a) & 255);
    endfunction

    assign src_data = pat(feed);

    // Controller stub and source feeder
    always @(posedge clk) begin
        if (!rst_n) begin
            ctl_busy <= 1'b0; ctl_err <= 8'h00; bcnt <= 0; ehold <= 0;
            feed <= 0; n_cmd <= 0; att <= 0; this_err <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                feed <= 0; n_cmd <= 0; att <= 0;
            end else if (src_ready) feed <= feed + 1;
            if (wbuf_we) wbuf[wbuf_idx] <= wbuf_data;
            if (cmd_valid) begin
                int gb;
                bit ok;
                gb = int'(cmd_word_off) * 4;
                if (!cmd_info && cmd_bank) gb += HALF;
                gb -= cur_req_off;
                ok = 1;
                for (int w = 0; w <= int'(cmd_size); w++)
                    if (wbuf[w] != {pat(gb+4*w+3), pat(gb+4*w+2), pat(gb+4*w+1), pat(gb+4*w)})
                        ok = 0;
                if (n_cmd < 64) begin
                    lg_woff[n_cmd] <= int'(cmd_word_off);
                    lg_size[n_cmd] <= int'(cmd_size);
                    lg_bank[n_cmd] <= int'(cmd_bank);
                    lg_info[n_cmd] <= int'(cmd_info);
                    lg_erase[n_cmd] <= int'(cmd_erase);
                    lg_dok[n_cmd] <= ok;
                end
                n_cmd <= n_cmd + 1;
                ctl_busy <= 1'b1;
                bcnt <= 3;
                this_err <= (att >= err_lo) && (att < err_hi);
                att <= att + 1;
            end else if (ctl_busy && !hang) begin
                if (bcnt == 1) begin
                    ctl_busy <= 1'b0;
                    ctl_err <= this_err ? 8'h10 : 8'h00;
                    ehold <= this_err ? 2 : 0;
                end else bcnt <= bcnt - 1;
            end else if (ehold != 0) begin
                ehold <= ehold - 1;
                if (ehold == 1) ctl_err <= 8'h00;
            end
            if (stuck) ctl_err <= 8'hff;
        end
    end

    int n_tests = 0, n_fail = 0;
    int r_st, r_fo, r_cyc;

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        stuck = 0; hang = 0; err_lo = 0; err_hi = 0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_req(int off, int len, bit er, bit inf);
        cur_req_off = off;
        @(negedge clk);
        req_offset = OFFW'(off); req_len = LENW'(len);
        req_erase = er; req_info = inf; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r_cyc = 0;
        while (!done && r_cyc < 5000) begin @(negedge clk); r_cyc++; end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", r_cyc, 0);
        end
        r_st = int'(status); r_fo = int'(fail_offset);
        @(negedge clk);
    endtask

    // Expected batches
    int ex_off [64];
    int ex_words [64];
    int ex_n;

    task automatic plan(int off, int len, bit er);
        ex_n = 0;
        while (len > 0 && ex_n < 64) begin
            int n;
            n = len;
            if (er) n = PAGE;
            else begin
                if (n > BW*4) n = BW*4;
                if (n > ROW - (off % ROW)) n = ROW - (off % ROW);
            end
            ex_off[ex_n] = off; ex_words[ex_n] = n / 4; ex_n++;
            off += n; len -= n;
        end
    endtask

    task automatic chk_cmd(int li, int bi, bit er, bit inf);
        int eb, ew;
        eb = inf ? 1 : (ex_off[bi] >= HALF ? 1 : 0);
        ew = (inf || ex_off[bi] < HALF) ? ex_off[bi] / 4 : (ex_off[bi] - HALF) / 4;
        chk(lg_bank[li] == eb, "R4 bank", lg_bank[li], eb);
        chk(lg_info[li] == int'(inf), "R4 info", lg_info[li], int'(inf));
        chk(lg_woff[li] == ew, er ? "R10 page offset" : "R2 word offset", lg_woff[li], ew);
        if (er) begin
            chk(lg_size[li] == 0 && lg_erase[li] == 1, "R10 erase size", lg_size[li], 0);
        end else begin
            chk(lg_size[li] == ex_words[bi] - 1, "R2 size", lg_size[li], ex_words[bi] - 1);
            chk(lg_dok[li], "R3 packed data", int'(lg_dok[li]), 1);
        end
    endtask

    task automatic clean_req(int off, int len, bit er, bit inf);
        int per;
        do_req(off, len, er, inf);
        plan(off, len, er);
        per = er ? 1 : 2;
        chk(r_st == 0, "R2 status ok", r_st, 0);
        chk(n_cmd == per * ex_n, er ? "R10 command count" : "R6 command count", n_cmd, per * ex_n);
        for (int k = 0; k < ex_n && per * k + per - 1 < 64; k++)
            for (int j = 0; j < per; j++) chk_cmd(per * k + j, k, er, inf);
    endtask

    task automatic reject_req(int off, int len, bit er, bit inf);
        do_req(off, len, er, inf);
        chk(r_st == 1, "R1 status", r_st, 1);
        chk(r_cyc == 0, "R1 latency", r_cyc, 0);
        chk(n_cmd == 0 && feed == 0, "R1 no activity", n_cmd + feed, 0);
        chk(r_fo == off, "R9 reject offset", r_fo, off);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        do_reset();
        // R11 reset state
        chk(!busy && !done && !cmd_valid && !src_ready, "R11 reset outputs",
            int'({busy, done, cmd_valid, src_ready}), 0);

        reject_req(2, 8, 0, 0);
        reject_req(0, 6, 0, 0);
        reject_req(1024, 2048, 1, 0);
        reject_req(0, 2048, 1, 1);

        // R11 zero length
        do_req(64, 0, 0, 0);
        chk(r_st == 0 && r_cyc == 0 && n_cmd == 0, "R11 zero length", r_st + r_cyc + n_cmd, 0);

        // R2 row split and buffer cap
        clean_req(248, 16, 0, 0);
        clean_req(0, 300, 0, 0);
        clean_req(200, 400, 0, 0);
        // R4 second bank and info bank
        clean_req(HALF + 32, 8, 0, 0);
        clean_req(HALF - 64, 128, 0, 0);
        clean_req(16, 40, 0, 1);

        // Random program requests
        for (int i = 0; i < 12; i++) begin
            int off, len;
            off = int'($urandom % (4096 - 200)) * 4;
            len = int'($urandom % 150) * 4 + 4;
            clean_req(off, len, 0, ($urandom % 4) == 0);
        end

        // R10 erase, including across the bank split
        clean_req(2048, 4096, 1, 0);
        clean_req(6144, 4096, 1, 0);

        // R5 recovery after two errors
        err_lo = 0; err_hi = 2;
        do_req(64, 64, 0, 0);
        chk(r_st == 0, "R5 retry recovers", r_st, 0);
        chk(n_cmd == 4, "R5 retry commands", n_cmd, 4);

        // R5 exhaustion
        err_lo = 0; err_hi = 100;
        do_req(512, 32, 0, 0);
        chk(r_st == 4, "R5 exhausted status", r_st, 4);
        chk(n_cmd == PT, "R5 exhausted commands", n_cmd, PT);
        chk(r_fo == 512, "R9 fail offset", r_fo, 512);

        // R6 extra pulse fails: ceiling grows by one
        err_lo = 1; err_hi = 100;
        do_req(512, 32, 0, 0);
        chk(r_st == 4, "R6 extra pulse status", r_st, 4);
        chk(n_cmd == PT + 1, "R6 extra pulse commands", n_cmd, PT + 1);

        // R9 second batch fails, third never starts
        err_lo = 2; err_hi = 100;
        do_req(0, 300, 0, 0);
        chk(r_st == 4, "R9 status", r_st, 4);
        chk(r_fo == 128, "R9 fail offset", r_fo, 128);
        chk(n_cmd == 2 + PT, "R9 stopped", n_cmd, 2 + PT);

        // R5 erase exhaustion
        err_lo = 0; err_hi = 100;
        do_req(2048, 4096, 1, 0);
        chk(r_st == 4 && n_cmd == ET, "R5 erase exhausted", n_cmd, ET);
        err_lo = 0; err_hi = 0;

        // R7 stuck error
        stuck = 1;
        do_req(256, 16, 0, 0);
        chk(r_st == 2, "R7 status", r_st, 2);
        chk(n_cmd == 0, "R7 no command", n_cmd, 0);
        do_reset();

        // R8 completion timeout
        hang = 1;
        do_req(1024, 16, 0, 0);
        chk(r_st == 3, "R8 status", r_st, 3);
        chk(n_cmd == 1 && r_fo == 1024, "R8 one command", n_cmd, 1);
        do_reset();

        clean_req(96, 64, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule